// File: doc/BRIEF.md
# Receive Line Status Tracker

This block sits between a UART receiver front end and a CPU register interface. It keeps the receive line error flags: overrun, parity error, framing error and break. Every decoded character arrives with three indications (parity error, framing error, break) and is stored with them as tags in a receive queue of `DEPTH` entries. In buffered mode a character's tags reach the status flags only when that character becomes the oldest entry in the queue. The CPU therefore sees each error together with the byte that caused it.

A break is stored as a 0x00 byte carrying the break tag. When a break entry takes effect, it sets the break flag and clears the parity, framing and overrun flags that the CPU has not yet cleared. In unbuffered mode the queue holds a single entry, and tags take effect on the same edge that stores the character. The CPU reads two registers. Reading the data register removes the oldest entry. Reading the status register returns the flags and then clears the four error flags.

The character input is a valid/ready stream. `in_ready` is always high, because a serial line cannot be stalled. When the queue has no room, the block accepts the beat, discards it and records an overrun.

Top module: `rx_line_status`

## Requirements
- R1: After reset the status register reads 0x00, `ls_irq` is low, and a data register read returns 0x00.
- R2: Status bit 0 (data ready) is 1 exactly when the queue holds an entry. A data read (`rd_addr`=0) returns the oldest entry and removes it, so entries come out in arrival order. A data read of an empty queue returns 0x00 and changes nothing.
- R3: In buffered mode the queue holds `DEPTH` entries. A character that arrives while the queue is full, with no data read on the same edge, is discarded and sets status bit 1 (overrun). `in_ready` is always 1.
- R4: In buffered mode an entry's parity and framing tags set status bit 2 (parity) and bit 3 (framing) on the first edge after that entry becomes the oldest in the queue, and not earlier.
- R5: A break is stored as data 0x00. When a break entry takes effect, status bit 4 (break) is set and bits 1, 2 and 3 are cleared.
- R6: In unbuffered mode (`buffered_en`=0) the queue holds one entry. Tags take effect on the edge that stores the character, with the same break rule as R5. A character that arrives while the entry is occupied sets overrun.
- R7: A status read (`rd_addr`=1) returns the value from before the read and clears bits 1 to 4 on that edge. Bit 0 is not affected. A flag that is set on that same edge stays set.
- R8: `ls_irq` is high exactly when `ls_ien` is 1 and any of status bits 1 to 4 is 1.
- R9: Status bits 7 to 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| buffered_en | input | 1 | 1: queued mode, 0: single-entry mode |
| in_valid | input | 1 | Character beat present |
| in_ready | output | 1 | Always 1; overflow becomes an overrun |
| in_data | input | 8 | Received character |
| in_perr | input | 1 | Parity error on this character |
| in_ferr | input | 1 | Framing error (stop bit sampled low) |
| in_brk | input | 1 | Line held low for a whole frame |
| rd_en | input | 1 | CPU read strobe, one cycle per access |
| rd_addr | input | 1 | 0: data register, 1: status register |
| rd_data | output | 8 | Read value of the selected register (combinational) |
| ls_ien | input | 1 | Line status interrupt enable |
| ls_irq | output | 1 | Line status interrupt request |

## Verification
The assertions assume that `buffered_en` changes only while the queue is empty. They also assume that `rd_en` is a single-cycle strobe with `rd_addr` stable while it is high. The stimulus switches modes only after the queue has been drained. It drives every input on the falling clock edge and raises each strobe for exactly one rising edge. The stimulus includes the one simultaneous event that R7 describes, a character arriving on the same edge as a status read, so that the set-beats-clear ordering is exercised.

// File: rtl/rxls_pkg.sv
package rxls_pkg;
  localparam int DW = 8;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          perr;
    logic          ferr;
    logic          brk;
  } rx_ent_t;

  // status register bit positions (software decodes these)
  localparam int ST_DR = 0;
  localparam int ST_OE = 1;
  localparam int ST_PE = 2;
  localparam int ST_FE = 3;
  localparam int ST_BI = 4;

  localparam logic RA_DATA = 1'b0;
  localparam logic RA_STAT = 1'b1;
endpackage

// File: rtl/rxls_fifo.sv
module rxls_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CAP) || pop);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP);
endmodule

// File: rtl/rxls_flags.sv
module rxls_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic apply,
  input  logic ap_perr,
  input  logic ap_ferr,
  input  logic ap_brk,
  input  logic ovr,
  input  logic clr,
  output logic oe,
  output logic pe,
  output logic fe,
  output logic bi
);
  logic oe_n, pe_n, fe_n, bi_n;

  always_comb begin
    // a status read clears first; events on the same edge are applied on top
    oe_n = clr ? 1'b0 : oe;
    pe_n = clr ? 1'b0 : pe;
    fe_n = clr ? 1'b0 : fe;
    bi_n = clr ? 1'b0 : bi;
    if (apply) begin
      if (ap_brk) begin
        bi_n = 1'b1;
        pe_n = 1'b0;
        fe_n = 1'b0;
        oe_n = 1'b0;
      end else begin
        pe_n = pe_n | ap_perr;
        fe_n = fe_n | ap_ferr;
      end
    end
    if (ovr) oe_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe <= 1'b0;
      pe <= 1'b0;
      fe <= 1'b0;
      bi <= 1'b0;
    end else begin
      oe <= oe_n;
      pe <= pe_n;
      fe <= fe_n;
      bi <= bi_n;
    end
  end

  assert_rd_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !apply && !ovr) |=> !oe && !pe && !fe && !bi);
  assert_brk_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && ap_brk) |=> bi && !pe && !fe);
  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && apply && !ap_brk && ap_ferr) |=> fe);
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rxls_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buffered_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_perr,
  input  logic          in_ferr,
  input  logic          in_brk,
  input  logic          rd_en,
  input  logic          rd_addr,
  output logic [7:0]    rd_data,
  input  logic          ls_ien,
  output logic          ls_irq
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int EW = $bits(rx_ent_t);
  localparam logic [CW-1:0] CAP_BUF = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_ONE = CW'(1);

  logic [CW-1:0] count;
  logic [EW-1:0] head_raw;
  rx_ent_t       head, in_ent;
  logic          pop, accept, ovr, clr;
  logic          head_done, head_fresh;
  logic          apply, ap_perr, ap_ferr, ap_brk;
  logic          oe, pe, fe, bi;
  logic [CW-1:0] cap;
  logic [7:0]    status;

  assign in_ready = 1'b1;
  assign cap      = buffered_en ? CAP_BUF : CAP_ONE;
  assign pop      = rd_en && (rd_addr == RA_DATA) && (count != '0);
  assign clr      = rd_en && (rd_addr == RA_STAT);
  assign accept   = in_valid && ((count < cap) || pop);
  assign ovr      = in_valid && !accept;

  always_comb begin
    in_ent.data = in_brk ? '0 : in_data;
    in_ent.perr = in_perr;
    in_ent.ferr = in_ferr;
    in_ent.brk  = in_brk;
  end

  rxls_fifo #(.DEPTH(DEPTH), .W(EW)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .wdata (in_ent),
    .pop   (pop),
    .rdata (head_raw),
    .count (count)
  );

  assign head = head_raw;

  // head tags take effect once per entry, on the edge after it becomes oldest
  assign head_fresh = buffered_en && (count != '0) && !head_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      head_done <= 1'b0;
    else if (pop)                    head_done <= !buffered_en && accept;
    else if (head_fresh)             head_done <= 1'b1;
    else if (!buffered_en && accept) head_done <= 1'b1;
  end

  always_comb begin
    apply   = 1'b0;
    ap_perr = 1'b0;
    ap_ferr = 1'b0;
    ap_brk  = 1'b0;
    if (head_fresh) begin
      apply   = 1'b1;
      ap_perr = head.perr;
      ap_ferr = head.ferr;
      ap_brk  = head.brk;
    end else if (!buffered_en && accept) begin
      apply   = 1'b1;
      ap_perr = in_ent.perr;
      ap_ferr = in_ent.ferr;
      ap_brk  = in_ent.brk;
    end
  end

  rxls_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .apply   (apply),
    .ap_perr (ap_perr),
    .ap_ferr (ap_ferr),
    .ap_brk  (ap_brk),
    .ovr     (ovr),
    .clr     (clr),
    .oe      (oe),
    .pe      (pe),
    .fe      (fe),
    .bi      (bi)
  );

  always_comb begin
    status        = '0;
    status[ST_DR] = (count != '0);
    status[ST_OE] = oe;
    status[ST_PE] = pe;
    status[ST_FE] = fe;
    status[ST_BI] = bi;
  end

  always_comb begin
    if (rd_addr == RA_STAT)   rd_data = status;
    else if (count != '0)     rd_data = head.data;
    else                      rd_data = '0;
  end

  assign ls_irq = ls_ien && (oe || pe || fe || bi);

  assert_overrun_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !accept) |=> oe);
  assert_unbuf_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!buffered_en && accept && in_ferr && !in_brk) |=> fe);
  assert_brk_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (head_fresh && head.brk) |-> head.data == '0);
  assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == RA_DATA && count == '0) |=> $stable(count));
endmodule

// File: tb/sim_rx_line_status.sv
`timescale 1ns/1ps
module sim_rx_line_status;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       buffered_en = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_perr = 1'b0, in_ferr = 1'b0, in_brk = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       ls_ien = 1'b0;
  logic       ls_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_line_status #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .buffered_en(buffered_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_perr(in_perr), .in_ferr(in_ferr), .in_brk(in_brk),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ls_ien(ls_ien), .ls_irq(ls_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic p, input logic f, input logic b);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_perr = p; in_ferr = f; in_brk = b;
    @(posedge clk); #1;
    in_valid = 1'b0; in_perr = 1'b0; in_ferr = 1'b0; in_brk = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 v = rd_data;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] dat(input int i);
    return 8'(i * 37 + 5);
  endfunction
  function automatic logic pbit(input int i);
    return (i % 3) == 1;
  endfunction
  function automatic logic fbit(input int i);
    return (i % 5) == 2;
  endfunction

  initial begin
    logic [7:0] v;
    logic [7:0] e;
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 irq", {7'b0, ls_irq}, 8'h00);
    rd(1'b1, v); chk("R1 status", v, 8'h00);
    rd(1'b0, v); chk("R1 empty data", v, 8'h00);
    chk("R3 ready", {7'b0, in_ready}, 8'h01);

    // buffered sweep: fill, overrun, drain with per-head flags (R2 R3 R4 R8 R9)
    ls_ien = 1'b1;
    for (int i = 0; i < DEPTH; i++) send(dat(i), pbit(i), fbit(i), 1'b0);
    idle(1);
    rd(1'b1, v); chk("R4 only head flags", v, 8'h01);
    send(8'hEE, 1'b1, 1'b1, 1'b0);
    chk("R8 irq on overrun", {7'b0, ls_irq}, 8'h01);
    rd(1'b1, v); chk("R3 overrun", v, 8'h03);
    rd(1'b1, v); chk("R7 cleared", v, 8'h01);
    for (int i = 0; i < DEPTH; i++) begin
      rd(1'b0, v); chk("R2 order", v, dat(i));
      idle(1);
      if (i < DEPTH - 1) e = {4'b0, fbit(i+1), pbit(i+1), 1'b0, 1'b1};
      else e = 8'h00;
      chk("R8 irq level", {7'b0, ls_irq}, {7'b0, e[2] | e[3]});
      rd(1'b1, v); chk("R4 head flags R9", v, e);
    end

    // break at head overrides pending errors and overrun (R5)
    for (int j = 0; j < DEPTH - 2; j++) send(8'(j + 8'h80), 1'b0, 1'b0, 1'b0);
    send(8'hC4, 1'b1, 1'b1, 1'b0);
    send(8'hFF, 1'b0, 1'b0, 1'b1);
    send(8'h99, 1'b0, 1'b0, 1'b0);
    chk("R3 overrun irq", {7'b0, ls_irq}, 8'h01);
    for (int j = 0; j < DEPTH - 2; j++) begin
      rd(1'b0, v); chk("R2 order2", v, 8'(j + 8'h80));
    end
    rd(1'b0, v); chk("R2 tagged data", v, 8'hC4);
    idle(1);
    rd(1'b1, v); chk("R5 break override", v, 8'h11);
    rd(1'b0, v); chk("R5 break zero", v, 8'h00);
    rd(1'b1, v); chk("R5 cleared", v, 8'h00);

    // unbuffered mode (R6)
    buffered_en = 1'b0;
    send(8'h3C, 1'b0, 1'b1, 1'b0);
    rd(1'b1, v); chk("R6 immediate fe", v, 8'h09);
    send(8'h44, 1'b0, 1'b0, 1'b0);
    rd(1'b1, v); chk("R6 single overrun", v, 8'h03);
    rd(1'b0, v); chk("R6 kept first", v, 8'h3C);
    send(8'h77, 1'b0, 1'b0, 1'b1);
    rd(1'b1, v); chk("R6 immediate break", v, 8'h11);
    rd(1'b0, v); chk("R6 break zero", v, 8'h00);
    rd(1'b0, v); chk("R2 empty no pop", v, 8'h00);
    rd(1'b1, v); chk("R2 empty status", v, 8'h00);

    // R7 set on the same edge as a status read survives
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h5A; in_ferr = 1'b1;
    rd_en = 1'b1; rd_addr = 1'b1;
    #1 v = rd_data;
    @(posedge clk); #1;
    in_valid = 1'b0; in_ferr = 1'b0; rd_en = 1'b0;
    chk("R7 pre-clear value", v, 8'h00);
    rd(1'b1, v); chk("R7 set wins", v, 8'h09);
    rd(1'b0, v); chk("R7 data", v, 8'h5A);

    // R8 enable gating
    ls_ien = 1'b0;
    send(8'h12, 1'b1, 1'b0, 1'b0);
    chk("R8 masked", {7'b0, ls_irq}, 8'h00);
    ls_ien = 1'b1; #1;
    chk("R8 enabled", {7'b0, ls_irq}, 8'h01);
    rd(1'b1, v); chk("R8 status", v, 8'h05);
    chk("R8 irq cleared", {7'b0, ls_irq}, 8'h00);
    rd(1'b0, v); chk("R6 data", v, 8'h12);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule